// File: doc/BRIEF.md
# Two-Pad Serial Button Port

This block lets a processor read two eight-button game pads through two byte-wide locations. One shared strobe, set by a write to the first location, decides how the pads behave. While the strobe is high, a read returns the live state of the pad's first button, and nothing moves. When a write brings the strobe low, the block captures each pad's button vector into its own shift register. Each read after that hands out one button and refills the vacated end with a one, so every read past the eighth returns 1.

Only bit 0 of a read byte comes from the pad. Bits 7 to 1 repeat the last value seen on the processor data bus, which arrives on the `open_bus` input. A read at any other address returns that bus value unchanged. A small two-state machine controls the strobe:

- `ST_SERIAL`: the strobe is low and reads shift the registers. This is the reset state.
- `ST_LATCH`: the strobe is high.

The machine has three transitions:

- SET_STROBE: `ST_SERIAL` to `ST_LATCH`, on a write with bit 0 = 1 to the strobe address.
- DROP_STROBE: `ST_LATCH` to `ST_SERIAL`, on a write with bit 0 = 0. This transition also loads both shift registers.
- Every other write keeps the current state.

Top module: `joypad_port`

## Requirements
- R1: After reset the strobe is low and both shift registers hold all ones, so reads at either pad address return 1 in bit 0 before any strobe write.
- R2: Only a write to the strobe address (0x4016) changes the strobe, taking its new level from data bit 0. A write to 0x4017 leaves the strobe and both registers unchanged.
- R3: While the strobe is high, a read returns the addressed pad's live button bit 0 (A) in bit 0 and does not advance its register.
- R4: A write that takes the strobe from high to low captures both pads' button vectors in that clock edge.
- R5: After the capture, successive reads return the pad's button vector bits 0 to 7 in that order: A, B, Select, Start, Up, Down, Left, Right. `pad_buttons[7:0]` is pad 0 and `pad_buttons[15:8]` is pad 1, and a 1 means pressed.
- R6: Each read while the strobe is low shifts that pad's register once and fills the top with 1. Every read after the eighth returns 1.
- R7: Address 0x4016 reads pad 0 and address 0x4017 reads pad 1. A read of one pad does not advance the other pad.
- R8: For a read at either pad address, `rd_data[7:1]` equals `open_bus[7:1]`.
- R9: A write with bit 0 = 0 while the strobe is already low does not recapture. The serial stream continues where it was.
- R10: A read at any other address returns `open_bus` in full and shifts neither register.
- R11: Button changes after the capture do not alter the serial stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe for this cycle |
| rd_en | input | 1 | Processor read strobe for this cycle |
| addr | input | 16 | Processor address |
| wr_data | input | 8 | Write data; only bit 0 is used |
| open_bus | input | 8 | Last value seen on the processor data bus |
| pad_buttons | input | 16 | Live buttons, pad 1 in [15:8], pad 0 in [7:0] |
| rd_data | output | 8 | Read byte, valid combinationally in the read cycle |

## Verification
The bench walks a sparse button pattern through all eight positions and on into the ones fill. A wrong bit order or a fill of zero would show up as mismatches at fixed read counts. It holds the strobe high while reading several times and toggles the live A button. A design that shifted during the strobe, or that returned the captured value instead of the live one, would return the wrong value on the second or third read. It writes zero a second time while the strobe is already low, changes buttons after the capture and writes to the second pad address. Each of these would corrupt the stream if the design reloaded on a level instead of an edge, or decoded the strobe address loosely. It also reads the two pads interleaved and at a foreign address, which catches shared shift enables and open-bus bits dropped in the merge.

// File: rtl/joypad_pkg.sv
package joypad_pkg;
    typedef enum logic {
        ST_SERIAL = 1'b0,
        ST_LATCH  = 1'b1
    } strobe_state_e;
endpackage

// File: rtl/joypad_strobe_fsm.sv
module joypad_strobe_fsm
    import joypad_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'h4016
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_bit,
    output logic              strobe_hi,
    output logic              load_pulse
);
    strobe_state_e state_q, state_d;
    logic          wr_hit;

    assign wr_hit = wr_en && (addr == STROBE_ADDR);

    // Next-state logic: SET_STROBE and DROP_STROBE; other writes hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SERIAL: if (wr_hit && wr_bit)  state_d = ST_LATCH;
            ST_LATCH:  if (wr_hit && !wr_bit) state_d = ST_SERIAL;
            default:   state_d = ST_SERIAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SERIAL;
        else        state_q <= state_d;
    end

    always_comb begin
        strobe_hi  = 1'b0;
        load_pulse = 1'b0;
        unique case (state_q)
            ST_LATCH: begin
                strobe_hi  = 1'b1;
                load_pulse = wr_hit && !wr_bit;
            end
            ST_SERIAL: begin
                strobe_hi  = 1'b0;
                load_pulse = 1'b0;
            end
            default: begin
                strobe_hi  = 1'b0;
                load_pulse = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/joypad_shifter.sv
module joypad_shifter #(
    parameter int NUM_BUTTONS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   shift,
    input  logic [NUM_BUTTONS-1:0] buttons,
    output logic [NUM_BUTTONS-1:0] sr_q,
    output logic                   serial_bit
);
    // Load has priority; shifting moves toward bit 0 and feeds ones at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '1;
        else if (load)  sr_q <= buttons;
        else if (shift) sr_q <= {1'b1, sr_q[NUM_BUTTONS-1:1]};
    end

    assign serial_bit = sr_q[0];
endmodule

// File: rtl/joypad_port.sv
module joypad_port #(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter int                NUM_BUTTONS = 8,
    parameter int                NUM_PADS    = 2,
    parameter logic [ADDR_W-1:0] PORT0_ADDR  = 16'h4016
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [DATA_W-1:0]               open_bus,
    input  logic [NUM_PADS*NUM_BUTTONS-1:0] pad_buttons,
    output logic [DATA_W-1:0]               rd_data
);
    localparam int SR_ALL_W = NUM_PADS * NUM_BUTTONS;

    logic                strobe_hi;
    logic                load_pulse;
    logic [SR_ALL_W-1:0] sr_all;
    logic [NUM_PADS-1:0] rd_hit;
    logic [NUM_PADS-1:0] pad_bit;
    logic                unused_bits;

    assign unused_bits = ^{wr_data[DATA_W-1:1], open_bus[0]};

    joypad_strobe_fsm #(
        .ADDR_W      (ADDR_W),
        .STROBE_ADDR (PORT0_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_bit     (wr_data[0]),
        .strobe_hi  (strobe_hi),
        .load_pulse (load_pulse)
    );

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        localparam logic [ADDR_W-1:0] PAD_ADDR = ADDR_W'(PORT0_ADDR + i);
        logic ser;

        assign rd_hit[i] = rd_en && (addr == PAD_ADDR);

        joypad_shifter #(
            .NUM_BUTTONS (NUM_BUTTONS)
        ) u_shifter (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_pulse),
            .shift      (rd_hit[i] && !strobe_hi),
            .buttons    (pad_buttons[i*NUM_BUTTONS +: NUM_BUTTONS]),
            .sr_q       (sr_all[i*NUM_BUTTONS +: NUM_BUTTONS]),
            .serial_bit (ser)
        );

        assign pad_bit[i] = strobe_hi ? pad_buttons[i*NUM_BUTTONS] : ser;
    end

    always_comb begin
        rd_data = open_bus;
        for (int i = 0; i < NUM_PADS; i++) begin
            if (rd_hit[i]) rd_data = {open_bus[DATA_W-1:1], pad_bit[i]};
        end
    end
endmodule

// File: rtl/joypad_port_chk.sv
module joypad_port_chk #(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter int                NUM_BUTTONS = 8,
    parameter int                NUM_PADS    = 2,
    parameter logic [ADDR_W-1:0] PORT0_ADDR  = 16'h4016
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [DATA_W-1:0]               wr_data,
    input logic [DATA_W-1:0]               open_bus,
    input logic [NUM_PADS*NUM_BUTTONS-1:0] pad_buttons,
    input logic [DATA_W-1:0]               rd_data,
    input logic                            strobe_hi,
    input logic [NUM_PADS*NUM_BUTTONS-1:0] sr_all
);
    localparam logic [ADDR_W-1:0] PORT1_ADDR = ADDR_W'(PORT0_ADDR + 1);

    a_r3_live_a: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_hi && rd_en && addr == PORT0_ADDR) |-> rd_data[0] == pad_buttons[0]);

    a_r3_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_hi && !wr_en) |=> $stable(sr_all));

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_hi && wr_en && addr == PORT0_ADDR && !wr_data[0])
        |=> (sr_all == $past(pad_buttons)) && !strobe_hi);

    a_r6_fill_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_hi && !wr_en && rd_en && addr == PORT0_ADDR)
        |=> sr_all[NUM_BUTTONS-1:0] == {1'b1, $past(sr_all[NUM_BUTTONS-1:1])});

    a_r8_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == PORT0_ADDR || addr == PORT1_ADDR))
        |-> rd_data[DATA_W-1:1] == open_bus[DATA_W-1:1]);
endmodule

bind joypad_port joypad_port_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_BUTTONS (NUM_BUTTONS),
    .NUM_PADS    (NUM_PADS),
    .PORT0_ADDR  (PORT0_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .open_bus    (open_bus),
    .pad_buttons (pad_buttons),
    .rd_data     (rd_data),
    .strobe_hi   (strobe_hi),
    .sr_all      (sr_all)
);

// File: tb/joypad_port_bench.sv
module joypad_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  open_bus = '0;
    logic [15:0] pad_buttons = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    joypad_port u_joypad_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .open_bus    (open_bus),
        .pad_buttons (pad_buttons),
        .rd_data     (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic read_expect(input string tag, input logic [15:0] a, input logic b0);
        logic [7:0] d;
        do_read(a, d);
        check(tag, {7'd0, d[0]}, {7'd0, b0});
    endtask

    task automatic capture(input logic [7:0] p0, input logic [7:0] p1);
        pad_buttons = {p1, p0};
        do_write(16'h4016, 8'h01);
        do_write(16'h4016, 8'h00);
    endtask

    task automatic t_reset;
        read_expect("R1 pad0 after reset", 16'h4016, 1'b1);
        read_expect("R1 pad1 after reset", 16'h4017, 1'b1);
    endtask

    task automatic t_order;
        logic [7:0] p0 = 8'b0100_0101;
        capture(p0, 8'h02);
        for (int k = 0; k < 8; k++) read_expect("R5 pad0 order", 16'h4016, p0[k]);
        read_expect("R6 ninth read", 16'h4016, 1'b1);
        read_expect("R6 tenth read", 16'h4016, 1'b1);
        read_expect("R7 pad1 first", 16'h4017, 1'b0);
        read_expect("R7 pad1 second", 16'h4017, 1'b1);
        read_expect("R7 pad1 third", 16'h4017, 1'b0);
    endtask

    task automatic t_live;
        pad_buttons = 16'h0001;
        do_write(16'h4016, 8'h01);
        read_expect("R3 live A 1", 16'h4016, 1'b1);
        read_expect("R3 no advance", 16'h4016, 1'b1);
        pad_buttons = 16'h0000;
        read_expect("R3 live A drops", 16'h4016, 1'b0);
        pad_buttons = 16'h0100;
        read_expect("R3 pad1 live A", 16'h4017, 1'b1);
        pad_buttons = 16'h0003;
        do_write(16'h4016, 8'h00);
        read_expect("R4 captured A", 16'h4016, 1'b1);
        read_expect("R4 captured B", 16'h4016, 1'b1);
        read_expect("R4 captured Select", 16'h4016, 1'b0);
    endtask

    task automatic t_open_bus;
        logic [7:0] d;
        capture(8'h01, 8'h00);
        open_bus = 8'hE0;
        do_read(16'h4016, d);
        check("R8 merged byte", d, 8'hE1);
        open_bus = 8'h5A;
        do_read(16'h4018, d);
        check("R10 foreign addr", d, 8'h5A);
        do_read(16'h4017, d);
        check("R8 pad1 merged", d, 8'h5A);
        open_bus = 8'h00;
    endtask

    task automatic t_no_reload;
        capture(8'h0A, 8'h00);
        read_expect("R9 A", 16'h4016, 1'b0);
        read_expect("R9 B", 16'h4016, 1'b1);
        pad_buttons = 16'h00FF;
        do_write(16'h4016, 8'h00);
        read_expect("R9 Select after rewrite", 16'h4016, 1'b0);
        read_expect("R9 Start after rewrite", 16'h4016, 1'b1);
        read_expect("R11 Up unaffected", 16'h4016, 1'b0);
    endtask

    task automatic t_other_write;
        capture(8'h00, 8'h00);
        pad_buttons = 16'h00FF;
        do_write(16'h4017, 8'h01);
        read_expect("R2 write 4017 ignored", 16'h4016, 1'b0);
        do_write(16'h4016, 8'hFE);
        read_expect("R2 bit0 zero no strobe", 16'h4016, 1'b0);
        for (int k = 2; k < 8; k++) read_expect("R11 held zeros", 16'h4016, 1'b0);
        read_expect("R6 fill after hold", 16'h4016, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_order();
        t_live();
        t_open_bus();
        t_no_reload();
        t_other_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule